// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is a three-line serial slave (data, shift clock, latch) that sits in front of a frequency synthesizer's control logic. All three serial lines and the power-down pin are brought into the fast system clock domain through a two-stage synchronizer. The block shifts data bits into a 24-bit window, and a rising latch edge commits the window as one word. A bit that travels in the word steers it to one of two registers. The setup register holds the reference divider, the operating modes and the per-band charge-pump current codes. The channel register holds the swallow and main counts, its own enable and the band select.

The block decodes both registers onto flat output fields. It chooses the charge-pump current code of the selected band. It also works out whether the synthesizer runs, from the power-down pin and the enable bit of whichever register was written last. A setup word that carries the reset flag clears both enable bits and raises a one-cycle reset pulse. The stored divider values are kept through that reset and through power-down.

Top module: `serial_cfg_port`

## Requirements
- R1: A word is the last 24 data bits shifted in on rising shift-clock edges, the first of them becoming bit 24 and the last bit 1; bits shifted earlier than those 24 have no effect.
- R2: A word is committed only on a rising latch edge seen while the shift clock is low; a rising latch edge while the shift clock is high commits nothing.
- R3: Bit 1 steers a committed word: 0 writes the channel register and pulses `chan_loaded`, 1 writes the setup register and pulses `setup_loaded`; at most one of the two pulses in any cycle.
- R4: A word whose bit 24 is 1 is dropped: no pulse, and no output changes.
- R5: Setup fields: bits 2–12 reference divider (bit 2 = LSB), bit 13 forced reload, bit 14 charge pump off, bits 15–16 band-2 current code, bit 17 detector polarity, bits 18–19 band-1 current code, bit 20 reset, bit 21 external resistor select, bit 22 setup enable, bit 23 lock-detect enable.
- R6: Channel fields: bits 2–8 swallow count (bit 2 = LSB), bits 9–19 main count (bit 9 = LSB), bits 20–21 unused, bit 22 channel enable, bit 23 band select.
- R7: A setup word with bit 20 set clears both enable bits and pulses `soft_reset` together with `setup_loaded`; the swallow count, main count and band select stay as they were, and the reset bit is never stored.
- R8: `cp_code` is the code of the selected band (band select 0 gives the band-1 code, 1 gives the band-2 code), as the value {higher-numbered bit, lower-numbered bit}: 0 = 0.7 mA, 1 = 0.9 mA, 2 = 1.9 mA, 3 = 2.5 mA.
- R9: `dev_enable` is 1 only when `pwr_up_n_pd` is high and the enable bit of the most recently written register is 1; after reset it is 0.
- R10: Stored fields change only on a write to their register; driving the power pin low leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock, data taken on its rising edge |
| ser_lat | input | 1 | Serial latch line, commits a word on its rising edge |
| pwr_up_n_pd | input | 1 | Power pin, low forces power-down |
| ref_div | output | 11 | Reference divider ratio |
| swallow_cnt | output | 7 | Swallow count |
| main_div | output | 11 | Main counter ratio |
| forced_reload | output | 1 | 1 = reload counters on write, 0 = on terminal count |
| cp_off | output | 1 | Charge pump held at high impedance |
| det_polarity | output | 1 | Phase detector slope, 1 = positive |
| ext_res_sel | output | 1 | Charge-pump current set by external resistor |
| ld_enable | output | 1 | Lock-detect output enable |
| band_sel | output | 1 | Selected band, 0 = band 1 |
| cp_code | output | 2 | Current code of the selected band |
| dev_enable | output | 1 | Synthesizer enabled |
| setup_loaded | output | 1 | One-cycle pulse on a setup write |
| chan_loaded | output | 1 | One-cycle pulse on a channel write |
| soft_reset | output | 1 | One-cycle pulse on a setup write carrying reset |

## Verification
The bench shifts in extra leading bits before a word. A design that counted bits, instead of keeping a sliding window, would then commit a shifted word with wrong fields. It raises the latch while the shift clock is high, and sends a word with bit 24 set; a design that decoded either one would give an unexpected load pulse or changed outputs. It alternates setup and channel writes with differing enable bits, toggles the power pin, and sends a reset word. These catch a design that ORs the two enables, loses fields in power-down, or clears the counts on reset. Divider fields at all-ones and band switches check field alignment and the current-code selection.

// File: rtl/scfg_pkg.sv
// Shared constants for the serial configuration port.
// Assumes a 24-bit word; bit N of the word sits at index N-1.
package scfg_pkg;
    localparam int WORD_W  = 24;
    localparam int RDIV_W  = 11;
    localparam int SWAL_W  = 7;
    localparam int MDIV_W  = 11;
    localparam int CODE_W  = 2;
    // index positions inside the captured word
    localparam int IDX_DEST    = 0;
    localparam int IDX_DEVSEL  = 23;
    localparam int IDX_RDIV    = 1;
    localparam int IDX_FORCE   = 12;
    localparam int IDX_CPOFF   = 13;
    localparam int IDX_CODE2   = 14;
    localparam int IDX_POL     = 16;
    localparam int IDX_CODE1   = 17;
    localparam int IDX_RST     = 19;
    localparam int IDX_EXTRES  = 20;
    localparam int IDX_EN      = 21;
    localparam int IDX_LDEN    = 22;
    localparam int IDX_SWAL    = 1;
    localparam int IDX_MDIV    = 8;
    localparam int IDX_BAND    = 22;
endpackage

// File: rtl/scfg_sync.sv
// Multi-stage synchronizer for a group of asynchronous inputs.
// Assumes each input is held longer than STAGES+1 system clocks.
module scfg_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    // Shift each input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
// Serial shift window and commit detector.
// Keeps the last WORD_W bits taken on shift-clock rising edges and
// pulses take_o for one cycle on a latch rise while the shift clock is low.
// Assumes synchronized inputs.
module scfg_shifter
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_s,
    input  logic              sck_s,
    input  logic              lat_s,
    output logic [WORD_W-1:0] word_o,
    output logic              take_o
);
    logic sck_d, lat_d;
    logic sck_rise;

    assign sck_rise = sck_s & ~sck_d;
    assign take_o   = lat_s & ~lat_d & ~sck_s;

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            lat_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
            lat_d <= lat_s;
        end
    end

    // Sliding window: newest bit enters at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_o <= '0;
        else if (sck_rise) word_o <= {word_o[WORD_W-2:0], dat_s};
    end

    AST_WINDOW_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(word_o)); // R1
endmodule

// File: rtl/scfg_regs.sv
// Setup and channel registers with field decode.
// Routes a committed word by its destination bit, drops it when the
// device-select bit is set, handles the self-clearing reset and tracks
// which register was written last.
module scfg_regs
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [WORD_W-1:0] word,
    output logic [RDIV_W-1:0] ref_div,
    output logic [SWAL_W-1:0] swallow_cnt,
    output logic [MDIV_W-1:0] main_div,
    output logic              forced_reload,
    output logic              cp_off,
    output logic              det_polarity,
    output logic              ext_res_sel,
    output logic              ld_enable,
    output logic              band_sel,
    output logic [CODE_W-1:0] cp_code,
    output logic              en_sel,
    output logic              setup_loaded,
    output logic              chan_loaded,
    output logic              soft_reset
);
    logic              setup_we, chan_we, rst_req;
    logic [CODE_W-1:0] code1_q, code2_q;
    logic              en1_q, en2_q, last_chan_q;

    assign setup_we = take & ~word[IDX_DEVSEL] &  word[IDX_DEST];
    assign chan_we  = take & ~word[IDX_DEVSEL] & ~word[IDX_DEST];
    assign rst_req  = word[IDX_RST];

    // Setup register, load pulses and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_div       <= '0;
            forced_reload <= 1'b0;
            cp_off        <= 1'b0;
            code2_q       <= '0;
            det_polarity  <= 1'b0;
            code1_q       <= '0;
            ext_res_sel   <= 1'b0;
            en1_q         <= 1'b0;
            ld_enable     <= 1'b0;
            setup_loaded  <= 1'b0;
            soft_reset    <= 1'b0;
        end else begin
            setup_loaded <= setup_we;
            soft_reset   <= setup_we & rst_req;
            if (setup_we) begin
                ref_div       <= word[IDX_RDIV +: RDIV_W];
                forced_reload <= word[IDX_FORCE];
                cp_off        <= word[IDX_CPOFF];
                code2_q       <= word[IDX_CODE2 +: CODE_W];
                det_polarity  <= word[IDX_POL];
                code1_q       <= word[IDX_CODE1 +: CODE_W];
                ext_res_sel   <= word[IDX_EXTRES];
                en1_q         <= word[IDX_EN] & ~rst_req;
                ld_enable     <= word[IDX_LDEN];
            end
        end
    end

    // Channel register; its enable is also cleared by a reset word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swallow_cnt <= '0;
            main_div    <= '0;
            band_sel    <= 1'b0;
            en2_q       <= 1'b0;
            chan_loaded <= 1'b0;
        end else begin
            chan_loaded <= chan_we;
            if (chan_we) begin
                swallow_cnt <= word[IDX_SWAL +: SWAL_W];
                main_div    <= word[IDX_MDIV +: MDIV_W];
                band_sel    <= word[IDX_BAND];
                en2_q       <= word[IDX_EN];
            end else if (setup_we && rst_req) begin
                en2_q <= 1'b0;
            end
        end
    end

    // Remember which register carries the governing enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_chan_q <= 1'b0;
        else if (chan_we)  last_chan_q <= 1'b1;
        else if (setup_we) last_chan_q <= 1'b0;
    end

    assign en_sel  = last_chan_q ? en2_q : en1_q;
    assign cp_code = band_sel ? code2_q : code1_q;

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(setup_loaded && chan_loaded)); // R3
    AST_RST_IS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> setup_loaded); // R7
    AST_RST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> !en_sel); // R7
    AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_we |=> $stable(ref_div)); // R10
    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_we |=> ($stable(main_div) && $stable(swallow_cnt))); // R10
endmodule

// File: rtl/serial_cfg_port.sv
// Top of the addressed serial configuration port.
// Synchronizes the serial lines and power pin, captures words and
// decodes them. Assumes the serial clock is at most a tenth of clk.
module serial_cfg_port
    import scfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_dat,
    input  logic              ser_clk,
    input  logic              ser_lat,
    input  logic              pwr_up_n_pd,
    output logic [RDIV_W-1:0] ref_div,
    output logic [SWAL_W-1:0] swallow_cnt,
    output logic [MDIV_W-1:0] main_div,
    output logic              forced_reload,
    output logic              cp_off,
    output logic              det_polarity,
    output logic              ext_res_sel,
    output logic              ld_enable,
    output logic              band_sel,
    output logic [CODE_W-1:0] cp_code,
    output logic              dev_enable,
    output logic              setup_loaded,
    output logic              chan_loaded,
    output logic              soft_reset
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0]  sync_q;
    logic [WORD_W-1:0] word;
    logic              take, en_sel;

    scfg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pwr_up_n_pd, ser_lat, ser_clk, ser_dat}),
        .sync_o  (sync_q)
    );

    scfg_shifter u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .dat_s  (sync_q[0]),
        .sck_s  (sync_q[1]),
        .lat_s  (sync_q[2]),
        .word_o (word),
        .take_o (take)
    );

    scfg_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .word          (word),
        .ref_div       (ref_div),
        .swallow_cnt   (swallow_cnt),
        .main_div      (main_div),
        .forced_reload (forced_reload),
        .cp_off        (cp_off),
        .det_polarity  (det_polarity),
        .ext_res_sel   (ext_res_sel),
        .ld_enable     (ld_enable),
        .band_sel      (band_sel),
        .cp_code       (cp_code),
        .en_sel        (en_sel),
        .setup_loaded  (setup_loaded),
        .chan_loaded   (chan_loaded),
        .soft_reset    (soft_reset)
    );

    assign dev_enable = sync_q[3] & en_sel;

    AST_EN_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        dev_enable |-> $past(pwr_up_n_pd, SYNC_STAGES)); // R9
endmodule

// File: tb/serial_cfg_port_tb.sv
// Scoreboard bench: write tasks push expected register images, a
// monitor pops one on every load pulse and compares all outputs.
module serial_cfg_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_dat = 1'b0, ser_clk = 1'b0, ser_lat = 1'b0, pwr = 1'b1;
    logic [10:0] ref_div, main_div;
    logic [6:0]  swallow_cnt;
    logic forced_reload, cp_off, det_polarity, ext_res_sel, ld_enable;
    logic band_sel, dev_enable, setup_loaded, chan_loaded, soft_reset;
    logic [1:0]  cp_code;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .ser_lat(ser_lat), .pwr_up_n_pd(pwr), .ref_div(ref_div),
        .swallow_cnt(swallow_cnt), .main_div(main_div),
        .forced_reload(forced_reload), .cp_off(cp_off),
        .det_polarity(det_polarity), .ext_res_sel(ext_res_sel),
        .ld_enable(ld_enable), .band_sel(band_sel), .cp_code(cp_code),
        .dev_enable(dev_enable), .setup_loaded(setup_loaded),
        .chan_loaded(chan_loaded), .soft_reset(soft_reset)
    );

    typedef struct packed {
        logic        is_setup;
        logic        rst;
        logic [10:0] r;
        logic [6:0]  a;
        logic [10:0] m;
        logic        frc, off, pol, ext, ld, band, en;
        logic [1:0]  code;
    } exp_t;

    exp_t q[$];
    // bench model of the stored state
    logic [10:0] m_r = '0, m_m = '0;
    logic [6:0]  m_a = '0;
    logic m_frc = 0, m_off = 0, m_pol = 0, m_ext = 0, m_ld = 0, m_band = 0;
    logic [1:0] m_c1 = '0, m_c2 = '0;
    logic m_en1 = 0, m_en2 = 0, m_lastch = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t snap(logic is_setup, logic rst);
        exp_t e;
        e.is_setup = is_setup; e.rst = rst;
        e.r = m_r; e.a = m_a; e.m = m_m;
        e.frc = m_frc; e.off = m_off; e.pol = m_pol; e.ext = m_ext;
        e.ld = m_ld; e.band = m_band;
        e.code = m_band ? m_c2 : m_c1;
        e.en = pwr & (m_lastch ? m_en2 : m_en1);
        return e;
    endfunction

    task automatic cmp(string req, exp_t e);
        chk(req, "ref_div", int'(ref_div), int'(e.r));
        chk(req, "swallow_cnt", int'(swallow_cnt), int'(e.a));
        chk(req, "main_div", int'(main_div), int'(e.m));
        chk(req, "mode bits", int'({forced_reload, cp_off, det_polarity, ext_res_sel, ld_enable}),
            int'({e.frc, e.off, e.pol, e.ext, e.ld}));
        chk(req, "band_sel", int'(band_sel), int'(e.band));
        chk("R8", "cp_code", int'(cp_code), int'(e.code));
        chk("R9", "dev_enable", int'(dev_enable), int'(e.en));
    endtask

    // Monitor: pop one expected image per load pulse.
    always @(negedge clk) begin
        if (rst_n && (setup_loaded || chan_loaded)) begin
            if (q.size() == 0) begin
                chk("R3", "unexpected load pulse", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R3", "setup_loaded", int'(setup_loaded), int'(e.is_setup));
                chk("R3", "chan_loaded", int'(chan_loaded), int'(!e.is_setup));
                chk("R7", "soft_reset", int'(soft_reset), int'(e.rst));
                cmp(e.is_setup ? "R5" : "R6", e);
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(logic b);
        ser_dat = b; ser_clk = 1'b0; wait_clk(5);
        ser_clk = 1'b1; wait_clk(5);
        ser_clk = 1'b0;
    endtask

    task automatic latch_low();
        wait_clk(5); ser_lat = 1'b1; wait_clk(5); ser_lat = 1'b0; wait_clk(8);
    endtask

    task automatic shift_word(logic [23:0] w);
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic write_setup(logic [10:0] r, logic frc, logic off, logic [1:0] c2,
                               logic pol, logic [1:0] c1, logic rst, logic ext,
                               logic en, logic ld);
        logic [23:0] w;
        w = {1'b0, ld, en, ext, rst, c1, pol, c2, off, frc, r, 1'b1};
        m_r = r; m_frc = frc; m_off = off; m_c2 = c2; m_pol = pol; m_c1 = c1;
        m_ext = ext; m_ld = ld; m_en1 = en & ~rst; m_lastch = 1'b0;
        if (rst) m_en2 = 1'b0;
        q.push_back(snap(1'b1, rst));
        shift_word(w); latch_low();
    endtask

    task automatic write_chan(logic [6:0] a, logic [10:0] m, logic en, logic band,
                              logic devsel);
        logic [23:0] w;
        w = {devsel, band, en, 2'b10, m, a, 1'b0};
        if (!devsel) begin
            m_a = a; m_m = m; m_en2 = en; m_band = band; m_lastch = 1'b1;
            q.push_back(snap(1'b0, 1'b0));
        end
        shift_word(w); latch_low();
    endtask

    initial begin
        wait_clk(4); rst_n = 1'b1; wait_clk(4);
        // reset state
        cmp("R9", snap(1'b0, 1'b0));
        chk("R3", "no pulse after reset", int'(setup_loaded | chan_loaded), 0);

        // R5 R8: setup fields, distinct codes per band
        write_setup(11'd65, 1, 0, 2'b11, 1, 2'b01, 0, 1, 1, 1);
        // R6 R9: channel, band 1 code
        write_chan(7'd36, 11'd91, 1, 0, 0);
        // R8: switch band
        write_chan(7'd36, 11'd91, 1, 1, 0);
        // R9: setup written last with enable 0
        write_setup(11'd65, 0, 1, 2'b10, 0, 2'b00, 0, 0, 0, 0);
        write_chan(7'd5, 11'd200, 1, 0, 0);

        // R10 R9: power pin low holds contents, disables
        pwr = 1'b0; wait_clk(6);
        cmp("R10", snap(1'b0, 1'b0));
        chk("R9", "dev_enable with pin low", int'(dev_enable), 0);
        pwr = 1'b1; wait_clk(6);
        cmp("R10", snap(1'b0, 1'b0));

        // R4: device-select bit set, word dropped
        write_chan(7'd99, 11'd1500, 0, 1, 1);
        chk("R4", "queue empty", q.size(), 0);
        cmp("R4", snap(1'b0, 1'b0));

        // R2: latch rise while shift clock high commits nothing
        shift_word({1'b0, 1'b1, 1'b0, 2'b00, 11'd7, 7'd3, 1'b0});
        ser_clk = 1'b1; wait_clk(5); ser_lat = 1'b1; wait_clk(5);
        ser_lat = 1'b0; wait_clk(5); ser_clk = 1'b0; wait_clk(8);
        cmp("R2", snap(1'b0, 1'b0));

        // R1: leading junk bits are pushed out of the window
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        write_chan(7'd127, 11'd2047, 1, 1, 0);
        write_setup(11'd2047, 1, 1, 2'b01, 1, 2'b10, 0, 1, 1, 1);

        // R7: reset word clears enables, keeps counts
        write_setup(11'd13, 0, 0, 2'b11, 0, 2'b01, 1, 1, 1, 0);
        chk("R7", "main_div kept", int'(main_div), 2047);
        chk("R7", "swallow_cnt kept", int'(swallow_cnt), 127);
        chk("R7", "dev_enable after reset", int'(dev_enable), 0);
        write_chan(7'd0, 11'd2, 1, 0, 0);
        chk("R9", "re-enabled by channel", int'(dev_enable), 1);

        wait_clk(10);
        chk("R3", "all expected pulses seen", q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule